// File: doc/BRIEF.md
# Chained Instruction Queue Fetcher

This block produces memory read requests for a single instruction queue whose commands are stored in a linked chain of buffer segments. Software first sets a segment start address and a segment size, counted in 64-bit words. It then grants fetch credit by adding word counts to a pending credit counter. Each instruction is 64 bytes (eight words). The block fetches one instruction for every eight pending credit words, walking forward through the current segment.

A segment holds `n` instructions followed by one more word. That last word holds the address of the next segment. When all `n` instructions of a segment have been fetched, the block issues a one-word read for that trailing word. The address it returns overwrites the live fetch address, and fetching resumes at the start of the new segment.

An in-flight counter rises when an instruction fetch is accepted and falls on each completion pulse from downstream. The queue enable gates only the start of new requests. The memory side uses a valid/ready request channel and a single-beat response channel. Only pointer reads expect a response at this block.

Top module: `iq_chain_fetch`

## Requirements
- R1: While `rst` is high, `req_valid` is 0, `inflight` is 0, `pend_words` is 0, `fetch_addr` is 0 and `cfg_err` is 1.
- R2: A write on `saddr_we` loads `saddr_wdata` with bits 5:0 forced to zero. From the next cycle, `fetch_addr` shows the address of the next read, always 64-byte aligned.
- R3: An instruction read (`req_is_ptr`=0) starts only when all of the following hold: `ena` is 1, `pend_words` is at least 8, `cfg_err` is 0 and the in-flight count is below its maximum. The read targets `fetch_addr`. When it is accepted, `pend_words` drops by 8 and `fetch_addr` advances by 64.
- R4: Segment size is `seg_size` = 8*n+1. After n instruction reads from one segment, and once credit for another instruction exists, the block issues a pointer read (`req_is_ptr`=1) at segment start + 64*n. This read consumes no credit.
- R5: Bits 48:6 of the pointer response data become the new `fetch_addr`, with bits 5:0 and bits above 48 ignored. The next instruction read is issued there, and the segment count restarts.
- R6: `cfg_err` is 1 one cycle after `seg_size` is not of the form 8*n+1 with n of at least 1, that is, when bits 2:0 are not 001 or the size is below 9. While it is 1, no new request starts.
- R7: `inflight` rises by 1 per accepted instruction read and falls by 1 per `done_pulse`. Both in the same cycle leave it unchanged. A `done_pulse` at 0 leaves it at 0.
- R8: When `inflight` is at its maximum (255 by default), no instruction read starts until a completion lowers it.
- R9: Clearing `ena` stops any new request from starting. A request already presented keeps `req_valid`, `req_addr` and `req_is_ptr` steady until `req_ready` accepts it.
- R10: `pend_words` accumulates every `db_add` written with `db_we`. Credit below 8 starts no read. Credit can build up across several writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ena | input | 1 | Queue enable |
| seg_size | input | 13 | Segment size in 64-bit words (8*n+1) |
| saddr_we | input | 1 | Load start address |
| saddr_wdata | input | 49 | Start byte address |
| db_we | input | 1 | Credit add strobe |
| db_add | input | 20 | Words of credit to add |
| done_pulse | input | 1 | One instruction finished downstream |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 49 | Read byte address |
| req_is_ptr | output | 1 | 1 = one-word next-pointer read, 0 = eight-word instruction read |
| rsp_valid | input | 1 | Pointer read data valid |
| rsp_data | input | 64 | Pointer read data |
| fetch_addr | output | 49 | Address of the next read |
| pend_words | output | 20 | Pending credit words |
| inflight | output | 8 | Instructions in flight |
| cfg_err | output | 1 | Segment size is malformed |

## Verification
A burst of credit that lands inside one segment checks that addresses step by 64 and credit is consumed. Split credit writes below eight words tell accumulation apart from fetching on any nonzero count. Crossing segment ends with segment lengths of one, three and 1023 instructions separates correct pointer placement from off-by-one walking. Pointer data with junk in the low and high bits shows that only bits 48:6 are loaded. Backpressure combined with a dropped enable distinguishes request holding from request withdrawal. A long burst that fills the in-flight counter tells the ceiling stall apart from wraparound.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,  // deciding what to fetch next
    FS_IREQ = 2'd1,  // instruction read presented
    FS_PREQ = 2'd2,  // next-pointer read presented
    FS_PRSP = 2'd3   // waiting for next-pointer data
  } fetch_st_e;
endpackage

// File: rtl/iqf_credit.sv
module iqf_credit #(
  parameter int DB_W    = 20,
  parameter int INSTR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            add_we,
  input  logic [DB_W-1:0] add_val,
  input  logic            take,
  output logic [DB_W-1:0] pend,
  output logic            pend_ok
);
  logic [DB_W-1:0] add_term;
  logic [DB_W-1:0] sub_term;

  assign add_term = add_we ? add_val : '0;
  assign sub_term = take ? DB_W'(INSTR_W) : '0;
  assign pend_ok  = (pend >= DB_W'(INSTR_W));

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend + add_term - sub_term;
  end
endmodule

// File: rtl/iqf_inflight.sv
module iqf_inflight #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         full
);
  localparam logic [W-1:0] CNT_MAX = '1;

  assign full = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (inc && !dec) begin
      if (cnt != CNT_MAX) cnt <= cnt + W'(1);
    end else if (dec && !inc) begin
      if (cnt != '0) cnt <= cnt - W'(1);
    end
  end
endmodule

// File: rtl/iqf_cfg_check.sv
module iqf_cfg_check #(
  parameter int SIZE_W = 13,
  localparam int NSEG_W = SIZE_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] size,
  output logic              err,
  output logic [NSEG_W-1:0] nseg
);
  logic bad_form;

  assign bad_form = (size[2:0] != 3'd1) || (size[SIZE_W-1:3] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      err  <= 1'b1;
      nseg <= '0;
    end else begin
      err  <= bad_form;
      nseg <= size[SIZE_W-1:3];
    end
  end
endmodule

// File: rtl/iqf_seg_walk.sv
module iqf_seg_walk
  import iqf_pkg::*;
#(
  parameter int ADDR_W   = 49,
  parameter int LINE_LSB = 6,
  parameter int NSEG_W   = 10,
  localparam int LINE_W  = ADDR_W - LINE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ena,
  input  logic              pend_ok,
  input  logic              blocked,
  input  logic [NSEG_W-1:0] nseg,
  input  logic              saddr_we,
  input  logic [LINE_W-1:0] saddr_line,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [LINE_W-1:0] rsp_line,
  output logic              req_valid,
  output logic              req_ptr,
  output logic [LINE_W-1:0] cur_line,
  output logic              instr_take
);
  fetch_st_e         st;
  logic [NSEG_W-1:0] idx;
  logic              go;
  logic              seg_done;

  assign go         = ena && pend_ok && !blocked;
  assign seg_done   = (idx >= nseg);
  assign req_valid  = (st == FS_IREQ) || (st == FS_PREQ);
  assign req_ptr    = (st == FS_PREQ);
  assign instr_take = (st == FS_IREQ) && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FS_IDLE;
      idx      <= '0;
      cur_line <= '0;
    end else begin
      case (st)
        FS_IDLE: if (go) st <= seg_done ? FS_PREQ : FS_IREQ;
        FS_IREQ: if (req_ready) begin
          st       <= FS_IDLE;
          idx      <= idx + NSEG_W'(1);
          cur_line <= cur_line + LINE_W'(1);
        end
        FS_PREQ: if (req_ready) st <= FS_PRSP;
        FS_PRSP: if (rsp_valid) begin
          st       <= FS_IDLE;
          idx      <= '0;
          cur_line <= rsp_line;
        end
        default: st <= FS_IDLE;
      endcase
      if (saddr_we) begin
        cur_line <= saddr_line;
        idx      <= '0;
      end
    end
  end
endmodule

// File: rtl/iq_chain_fetch.sv
module iq_chain_fetch #(
  parameter int ADDR_W   = 49,
  parameter int LINE_LSB = 6,
  parameter int SIZE_W   = 13,
  parameter int DB_W     = 20,
  parameter int INFL_W   = 8,
  parameter int DATA_W   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ena,
  input  logic [SIZE_W-1:0] seg_size,
  input  logic              saddr_we,
  input  logic [ADDR_W-1:0] saddr_wdata,
  input  logic              db_we,
  input  logic [DB_W-1:0]   db_add,
  input  logic              done_pulse,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_is_ptr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [DB_W-1:0]   pend_words,
  output logic [INFL_W-1:0] inflight,
  output logic              cfg_err
);
  localparam int LINE_W  = ADDR_W - LINE_LSB;
  localparam int NSEG_W  = SIZE_W - 3;
  localparam int INSTR_W = 8;

  logic              pend_ok;
  logic              infl_full;
  logic              instr_take;
  logic [NSEG_W-1:0] nseg;
  logic [LINE_W-1:0] cur_line;

  iqf_cfg_check #(.SIZE_W(SIZE_W)) u_cfg (
    .clk(clk), .rst(rst), .size(seg_size), .err(cfg_err), .nseg(nseg)
  );

  iqf_credit #(.DB_W(DB_W), .INSTR_W(INSTR_W)) u_credit (
    .clk(clk), .rst(rst), .add_we(db_we), .add_val(db_add),
    .take(instr_take), .pend(pend_words), .pend_ok(pend_ok)
  );

  iqf_inflight #(.W(INFL_W)) u_infl (
    .clk(clk), .rst(rst), .inc(instr_take), .dec(done_pulse),
    .cnt(inflight), .full(infl_full)
  );

  iqf_seg_walk #(.ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB), .NSEG_W(NSEG_W)) u_walk (
    .clk(clk), .rst(rst), .ena(ena), .pend_ok(pend_ok),
    .blocked(cfg_err || infl_full), .nseg(nseg),
    .saddr_we(saddr_we), .saddr_line(saddr_wdata[ADDR_W-1:LINE_LSB]),
    .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_line(rsp_data[ADDR_W-1:LINE_LSB]),
    .req_valid(req_valid), .req_ptr(req_is_ptr), .cur_line(cur_line),
    .instr_take(instr_take)
  );

  assign fetch_addr = {cur_line, {LINE_LSB{1'b0}}};
  assign req_addr   = fetch_addr;
endmodule

// File: rtl/iqf_chk.sv
module iqf_chk #(
  parameter int ADDR_W = 49,
  parameter int DB_W   = 20,
  parameter int INFL_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_is_ptr,
  input logic [ADDR_W-1:0] req_addr,
  input logic              done_pulse,
  input logic [DB_W-1:0]   pend_words,
  input logic [INFL_W-1:0] inflight,
  input logic              cfg_err
);
  localparam logic [INFL_W-1:0] IMAX = '1;

  // R9: a presented request is held steady until accepted
  a_r9_hold_req: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_is_ptr)));

  // R3: an accepted instruction read always had a full instruction of credit
  a_r3_credit: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_is_ptr) |-> (pend_words >= DB_W'(8)));

  // R7: accepted fetch without completion raises the count by one
  a_r7_inc: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_is_ptr && !done_pulse && inflight != IMAX)
      |=> (inflight == $past(inflight) + INFL_W'(1)));

  // R7: completion without fetch lowers a nonzero count by one
  a_r7_dec: assert property (@(posedge clk) disable iff (rst)
    (done_pulse && !(req_valid && req_ready && !req_is_ptr) && inflight != '0)
      |=> (inflight == $past(inflight) - INFL_W'(1)));

  // R8: no instruction read is presented with the counter at its ceiling
  a_r8_ceiling: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_ptr) |-> (inflight != IMAX));

  // R6: a malformed size keeps an idle queue idle
  a_r6_block: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !req_valid) |=> !req_valid);
endmodule

bind iq_chain_fetch iqf_chk #(.ADDR_W(ADDR_W), .DB_W(DB_W), .INFL_W(INFL_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_is_ptr(req_is_ptr), .req_addr(req_addr), .done_pulse(done_pulse),
  .pend_words(pend_words), .inflight(inflight), .cfg_err(cfg_err)
);

// File: tb/sim_iq_chain_fetch.sv
module sim_iq_chain_fetch;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst, ena, saddr_we, db_we, done_pulse, req_ready, rsp_valid;
  logic [12:0] seg_size;
  logic [48:0] saddr_wdata;
  logic [19:0] db_add;
  logic [63:0] rsp_data;
  logic        req_valid, req_is_ptr, cfg_err;
  logic [48:0] req_addr, fetch_addr;
  logic [19:0] pend_words;
  logic [7:0]  inflight;

  int total = 0;
  int bad   = 0;

  logic [48:0] log_addr [64];
  logic        log_ptr  [64];
  int          log_n  = 0;
  int          ptr_req = 0;
  int          ptr_srv = 0;
  logic [63:0] next_ptr = '0;

  always #(CLK_P/2) clk = ~clk;

  iq_chain_fetch u0 (
    .clk(clk), .rst(rst), .ena(ena), .seg_size(seg_size),
    .saddr_we(saddr_we), .saddr_wdata(saddr_wdata),
    .db_we(db_we), .db_add(db_add), .done_pulse(done_pulse),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_is_ptr(req_is_ptr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fetch_addr(fetch_addr), .pend_words(pend_words),
    .inflight(inflight), .cfg_err(cfg_err)
  );

  // request monitor: values seen at the edge are those of the handshake
  always @(posedge clk) begin
    if (!rst && req_valid && req_ready) begin
      if (log_n < 64) begin
        log_addr[log_n] = req_addr;
        log_ptr[log_n]  = req_is_ptr;
      end
      log_n = log_n + 1;
      if (req_is_ptr) ptr_req = ptr_req + 1;
    end
  end

  // pointer responder: one beat, one cycle after acceptance
  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (ptr_srv < ptr_req) begin
      rsp_valid = 1'b1;
      rsp_data  = next_ptr;
      ptr_srv   = ptr_srv + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_log(input string tag, input int pos, input logic [48:0] a, input logic p);
    chk({tag, " addr"}, 64'(log_addr[pos]), 64'(a));
    chk({tag, " ptr"},  64'(log_ptr[pos]),  64'(p));
  endtask

  task automatic credit(input int words);
    db_we = 1'b1; db_add = 20'(words);
    tick(1);
    db_we = 1'b0; db_add = '0;
  endtask

  task automatic load_saddr(input logic [48:0] a);
    saddr_we = 1'b1; saddr_wdata = a;
    tick(1);
    saddr_we = 1'b0;
  endtask

  task automatic done_n(input int n);
    for (int i = 0; i < n; i++) begin
      done_pulse = 1'b1; tick(1);
      done_pulse = 1'b0; tick(1);
    end
  endtask

  task automatic t_reset;
    tick(3);
    chk("R1 req_valid", 64'(req_valid), 64'd0);
    chk("R1 inflight", 64'(inflight), 64'd0);
    chk("R1 pend", 64'(pend_words), 64'd0);
    chk("R1 fetch_addr", 64'(fetch_addr), 64'd0);
    chk("R1 cfg_err", 64'(cfg_err), 64'd1);
    rst = 1'b0;
    tick(2);
  endtask

  task automatic t_basic;
    int b;
    load_saddr(49'h1015);
    chk("R2 aligned readback", 64'(fetch_addr), 64'h1000);
    chk("R6 good size", 64'(cfg_err), 64'd0);
    b = log_n;
    ena = 1'b1;
    credit(16);
    tick(10);
    chk("R3 count", 64'(log_n - b), 64'd2);
    chk_log("R3 first", b, 49'h1000, 1'b0);
    chk_log("R3 second", b + 1, 49'h1040, 1'b0);
    chk("R3 next addr", 64'(fetch_addr), 64'h1080);
    chk("R3 credit used", 64'(pend_words), 64'd0);
    chk("R7 inflight", 64'(inflight), 64'd2);
  endtask

  task automatic t_partial;
    int b;
    b = log_n;
    credit(4);
    tick(8);
    chk("R10 no fetch under 8", 64'(log_n - b), 64'd0);
    chk("R10 pend 4", 64'(pend_words), 64'd4);
    credit(4);
    tick(8);
    chk("R10 fetch after sum", 64'(log_n - b), 64'd1);
    chk_log("R10 third", b, 49'h1080, 1'b0);
    chk("R4 waits for credit", 64'(fetch_addr), 64'h10C0);
    chk("R7 inflight 3", 64'(inflight), 64'd3);
  endtask

  task automatic t_chain;
    int b;
    b = log_n;
    next_ptr = 64'hFFFE_0000_0020_003F;
    credit(16);
    tick(15);
    chk("R4 count", 64'(log_n - b), 64'd3);
    chk_log("R4 ptr read", b, 49'h10C0, 1'b1);
    chk_log("R5 new segment", b + 1, 49'h200000, 1'b0);
    chk_log("R5 walk", b + 2, 49'h200040, 1'b0);
    chk("R5 readback", 64'(fetch_addr), 64'h200080);
    chk("R4 no credit for ptr", 64'(pend_words), 64'd0);
    chk("R7 inflight 5", 64'(inflight), 64'd5);
  endtask

  task automatic t_inflight;
    done_n(3);
    chk("R7 dec", 64'(inflight), 64'd2);
    done_n(4);
    chk("R7 floor", 64'(inflight), 64'd0);
  endtask

  task automatic t_enable;
    int b;
    b = log_n;
    ena = 1'b0;
    credit(16);
    tick(10);
    chk("R9 disabled no fetch", 64'(log_n - b), 64'd0);
    chk("R9 credit kept", 64'(pend_words), 64'd16);
    next_ptr = 64'h3000;
    ena = 1'b1;
    tick(15);
    chk("R9 resume count", 64'(log_n - b), 64'd3);
    chk_log("R9 resume", b, 49'h200080, 1'b0);
    chk_log("R4 second ptr", b + 1, 49'h2000C0, 1'b1);
    chk_log("R5 second seg", b + 2, 49'h3000, 1'b0);
  endtask

  task automatic t_hold;
    int b;
    b = log_n;
    req_ready = 1'b0;
    credit(8);
    tick(3);
    chk("R9 presented", 64'(req_valid), 64'd1);
    chk("R9 addr", 64'(req_addr), 64'h3040);
    ena = 1'b0;
    tick(3);
    chk("R9 held valid", 64'(req_valid), 64'd1);
    chk("R9 held addr", 64'(req_addr), 64'h3040);
    req_ready = 1'b1;
    tick(5);
    chk("R9 accepted once", 64'(log_n - b), 64'd1);
    chk("R9 idle after", 64'(req_valid), 64'd0);
    credit(8);
    tick(8);
    chk("R9 no new after clear", 64'(log_n - b), 64'd1);
  endtask

  task automatic t_cfg;
    int b;
    load_saddr(49'h8000);
    seg_size = 13'd24;
    tick(2);
    chk("R6 bad low bits", 64'(cfg_err), 64'd1);
    b = log_n;
    ena = 1'b1;
    tick(8);
    chk("R6 blocked", 64'(log_n - b), 64'd0);
    seg_size = 13'd1;
    tick(2);
    chk("R6 zero n", 64'(cfg_err), 64'd1);
    next_ptr = 64'h9000;
    seg_size = 13'd9;
    tick(8);
    chk("R6 cleared", 64'(cfg_err), 64'd0);
    credit(8);
    tick(12);
    chk("R4 n=1 count", 64'(log_n - b), 64'd3);
    chk_log("R4 n=1 first", b, 49'h8000, 1'b0);
    chk_log("R4 n=1 ptr", b + 1, 49'h8040, 1'b1);
    chk_log("R5 n=1 next", b + 2, 49'h9000, 1'b0);
  endtask

  task automatic t_sat;
    ena = 1'b0;
    done_n(8);
    chk("R7 drained", 64'(inflight), 64'd0);
    load_saddr(49'h100000);
    seg_size = 13'd8185;
    tick(2);
    ena = 1'b1;
    credit(2080);
    tick(700);
    chk("R8 ceiling", 64'(inflight), 64'd255);
    chk("R8 credit left", 64'(pend_words), 64'd40);
    chk("R8 addr", 64'(fetch_addr), 64'h103FC0);
    done_n(1);
    tick(6);
    chk("R8 one more", 64'(inflight), 64'd255);
    chk("R8 credit after", 64'(pend_words), 64'd32);
    chk("R8 addr after", 64'(fetch_addr), 64'h104000);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; ena = 1'b0; saddr_we = 1'b0; saddr_wdata = '0;
    db_we = 1'b0; db_add = '0; done_pulse = 1'b0; req_ready = 1'b1;
    seg_size = 13'd25; rsp_data = '0;
    t_reset();
    t_basic();
    t_partial();
    t_chain();
    t_inflight();
    t_enable();
    t_hold();
    t_cfg();
    t_sat();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule